// File: doc/BRIEF.md
# Line-Scan Sensor Serial Controller

This block runs a serially programmed linear image sensor from a single-bit-wide on-chip RAM. After reset it replays a command image held at the bottom of the RAM. It shifts the image out one bit per sensor clock on the sensor's serial input, so the sensor's 8-bit instruction register is loaded from RAM contents and not from fixed logic. Once the command image has gone out, the serial input stays low for good.

From then on a reloadable down-counter paces the lines. At each expiry the controller arms capture. It then watches the sensor's serial output for framed pixel bytes. Each byte is one low start bit, eight data bits least significant first, and one high stop bit. The eight data bits are written one at a time into a fixed pixel region higher in the same RAM. After the last byte of a line a one-cycle done pulse is raised and the write address returns to the start of the region, so each line overwrites the previous one. With a 48 MHz system clock, a period value of 30240 gives a line every 630 µs, about 1600 lines per second. The default byte count of 102 matches a 102-pixel sensor.

Top module: `lscan_ctrl`

## Requirements
- R1: While `rst_n` is low, `ram_addr`, `sensor_sdin`, `ram_we`, `line_done` and `sensor_sclk` are all zero. This holds from the moment reset is applied, without waiting for a clock.
- R2: `sensor_sclk` is a square wave with a period of 2·SCLK_HALF system clocks, high for SCLK_HALF clocks. `sensor_sdin` only changes on the system clock edge at which `sensor_sclk` falls.
- R3: After reset, the value on `sensor_sdin` at rising sensor clock n+1 (n = 1..CMD_BITS) is the RAM bit at address n-1. These bits are read in ascending address order starting at address 0, one bit per sensor clock. At the first rising sensor clock `sensor_sdin` is still 0.
- R4: From the falling sensor clock after the last command bit onward, `sensor_sdin` stays 0. This includes every cycle in which a pixel bit is written.
- R5: A pixel byte is captured only after a low level on `sensor_sdout` is sampled at a rising sensor clock while the controller awaits a start bit. Idle high levels are skipped. Start and stop bits are never written.
- R6: Data bit b (0 = first received) of pixel byte j of a line is written to address PIX_BASE + 8·j + b. `ram_we` is high for exactly one cycle per data bit, and `ram_addr` advances by one in the following cycle.
- R7: After the stop bit of byte PIX_BYTES-1, `line_done` pulses high for one cycle. At that moment `ram_addr` is already back at PIX_BASE, and the next line overwrites the same region.
- R8: Capture of a new line is armed only when the line timer expires. The timer expires once right after the command phase and then every `line_period` system clocks. Each expiry reloads it from the current `line_period` input. Start bits that arrive between a `line_done` and the next expiry cause no write and no done pulse.
- R9: `ram_we` is asserted only for addresses in [PIX_BASE, PIX_BASE + 8·PIX_BYTES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_period | input | LINE_W | Line period in system clocks, loaded at each timer expiry (must be at least 1) |
| sensor_sclk | output | 1 | Serial clock to the sensor |
| sensor_sdin | output | 1 | Serial command data to the sensor, changes on falling sensor clock |
| sensor_sdout | input | 1 | Framed pixel stream from the sensor, sampled on rising sensor clock |
| ram_addr | output | ADDR_W | RAM bit address, shared by command reads and pixel writes |
| ram_rdata | input | 1 | RAM read bit for `ram_addr`, valid in the same cycle |
| ram_wdata | output | 1 | Pixel bit to store |
| ram_we | output | 1 | One-cycle write strobe for `ram_wdata` at `ram_addr` |
| line_done | output | 1 | One-cycle pulse after the last pixel byte of a line is stored |

## Verification
The bench builds the block with SCLK_HALF = 2, CMD_BITS = 16 and PIX_BYTES = 4, keeping PIX_BASE at 512, with a line period of 300 clocks. At these sizes a full line takes only a few hundred cycles. That lets all 256 pixel byte values pass through capture across 64 lines, both back to back and with idle-high gaps. Decoy frames are placed between a done pulse and the next timer expiry. A later change of `line_period` shows whether the new value takes effect at the following reload. Two resets with different 16-bit command images cover the full replay and the return to a quiet serial input.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

  typedef enum logic [2:0] {
    SQ_CMD        = 3'd0,
    SQ_WAIT_LINE  = 3'd1,
    SQ_WAIT_START = 3'd2,
    SQ_DATA       = 3'd3,
    SQ_STOP       = 3'd4
  } lsc_state_e;

endpackage

// File: rtl/lscan_sclk_gen.sv
module lscan_sclk_gen #(
  parameter int SCLK_HALF = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_d;
  logic          wrap;

  always_comb begin
    wrap     = (cnt_q == LAST);
    cnt_d    = wrap ? '0 : cnt_q + CW'(1);
    sclk_d   = wrap ? ~sclk : sclk;
    rise_evt = wrap & ~sclk;
    fall_evt = wrap & sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sclk  <= sclk_d;
    end
  end

endmodule

// File: rtl/lscan_line_timer.sv
module lscan_line_timer #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LINE_W-1:0] period,
  output logic              tick
);
  logic [LINE_W-1:0] tmr_q, tmr_d;

  always_comb begin
    tick = run && (tmr_q == '0);
    if (!run)
      tmr_d = '0;
    else if (tick)
      tmr_d = period - LINE_W'(1);
    else
      tmr_d = tmr_q - LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

endmodule

// File: rtl/lscan_seq.sv
module lscan_seq
  import lscan_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int CMD_BITS  = 32,
  parameter int PIX_BASE  = 512,
  parameter int PIX_BYTES = 102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              tick,
  input  logic              sdout,
  input  logic              rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              sdin,
  output logic              we,
  output logic              wdata,
  output logic              done,
  output logic              run
);
  localparam logic [ADDR_W-1:0] CMD_END = ADDR_W'(CMD_BITS);
  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(PIX_BASE);
  localparam logic [ADDR_W-1:0] PEND    = ADDR_W'(PIX_BASE + 8 * PIX_BYTES);

  lsc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sdin_q, sdin_d;
  logic              we_q, we_d;
  logic              wd_q, wd_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    sdin_d  = sdin_q;
    we_d    = 1'b0;
    wd_d    = wd_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_CMD: begin
        if (fall_evt) begin
          if (addr_q == CMD_END) begin
            sdin_d  = 1'b0;
            addr_d  = BASE;
            state_d = SQ_WAIT_LINE;
          end else begin
            sdin_d = rdata;
            addr_d = addr_q + ADDR_W'(1);
          end
        end
      end
      SQ_WAIT_LINE: begin
        if (tick) state_d = SQ_WAIT_START;
      end
      SQ_WAIT_START: begin
        if (rise_evt && !sdout) state_d = SQ_DATA;
      end
      SQ_DATA: begin
        if (rise_evt) begin
          we_d = 1'b1;
          wd_d = sdout;
        end
        if (we_q) begin
          addr_d = addr_q + ADDR_W'(1);
          if (&addr_q[2:0]) state_d = SQ_STOP;
        end
      end
      SQ_STOP: begin
        if (rise_evt) begin
          if (addr_q == PEND) begin
            done_d  = 1'b1;
            addr_d  = BASE;
            state_d = SQ_WAIT_LINE;
          end else begin
            state_d = SQ_WAIT_START;
          end
        end
      end
      default: state_d = SQ_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_CMD;
      addr_q  <= '0;
      sdin_q  <= 1'b0;
      we_q    <= 1'b0;
      wd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      sdin_q  <= sdin_d;
      we_q    <= we_d;
      wd_q    <= wd_d;
      done_q  <= done_d;
    end
  end

  assign addr  = addr_q;
  assign sdin  = sdin_q;
  assign we    = we_q;
  assign wdata = wd_q;
  assign done  = done_q;
  assign run   = (state_q != SQ_CMD);

endmodule

// File: rtl/lscan_ctrl.sv
module lscan_ctrl #(
  parameter int SCLK_HALF = 24,
  parameter int ADDR_W    = 11,
  parameter int CMD_BITS  = 32,
  parameter int PIX_BASE  = 512,
  parameter int PIX_BYTES = 102,
  parameter int LINE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_period,
  output logic              sensor_sclk,
  output logic              sensor_sdin,
  input  logic              sensor_sdout,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic              ram_rdata,
  output logic              ram_wdata,
  output logic              ram_we,
  output logic              line_done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       rise_evt, fall_evt, tick, run;

  // assert at once, release two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lscan_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sclk     (sensor_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  lscan_line_timer #(.LINE_W(LINE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (run),
    .period (line_period),
    .tick   (tick)
  );

  lscan_seq #(
    .ADDR_W    (ADDR_W),
    .CMD_BITS  (CMD_BITS),
    .PIX_BASE  (PIX_BASE),
    .PIX_BYTES (PIX_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .tick     (tick),
    .sdout    (sensor_sdout),
    .rdata    (ram_rdata),
    .addr     (ram_addr),
    .sdin     (sensor_sdin),
    .we       (ram_we),
    .wdata    (ram_wdata),
    .done     (line_done),
    .run      (run)
  );

endmodule

// File: rtl/lscan_ctrl_chk.sv
module lscan_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int PIX_BASE  = 512,
  parameter int PIX_BYTES = 102
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sensor_sclk,
  input logic              sensor_sdin,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic              line_done
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(PIX_BASE);
  localparam logic [ADDR_W-1:0] PEND = ADDR_W'(PIX_BASE + 8 * PIX_BYTES);

  assert_sdin_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sensor_sdin) |-> $fell(sensor_sclk));

  assert_quiet_during_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !sensor_sdin);

  assert_we_single_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (!ram_we && ram_addr == $past(ram_addr) + ADDR_W'(1)));

  assert_done_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (ram_addr == BASE && !ram_we));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_write_in_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= BASE && ram_addr < PEND));

endmodule

bind lscan_ctrl lscan_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .PIX_BASE  (PIX_BASE),
  .PIX_BYTES (PIX_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sensor_sclk (sensor_sclk),
  .sensor_sdin (sensor_sdin),
  .ram_addr    (ram_addr),
  .ram_we      (ram_we),
  .line_done   (line_done)
);

// File: tb/lscan_ctrl_tb_top.sv
`timescale 1ns/1ps
module lscan_ctrl_tb_top;
  localparam int HALF   = 2;
  localparam int AW     = 11;
  localparam int NCMD   = 16;
  localparam int BASE   = 512;
  localparam int NBYTES = 4;
  localparam int LW     = 16;

  logic          clk;
  logic          rst_n;
  logic [LW-1:0] line_period;
  logic          sensor_sclk, sensor_sdin, sensor_sdout;
  logic [AW-1:0] ram_addr;
  logic          ram_rdata, ram_wdata, ram_we, line_done;

  logic          mem [0:(1<<AW)-1];
  logic [15:0]   cmd_img;
  logic          rec [0:63];
  int            rise_n, fall_n, cyc, e_cyc, we_tot, done_tot;
  int            checks, failures;

  lscan_ctrl #(
    .SCLK_HALF(HALF), .ADDR_W(AW), .CMD_BITS(NCMD),
    .PIX_BASE(BASE), .PIX_BYTES(NBYTES), .LINE_W(LW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .line_period(line_period),
    .sensor_sclk(sensor_sclk), .sensor_sdin(sensor_sdin), .sensor_sdout(sensor_sdout),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .line_done(line_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bit-wide RAM; command region served from cmd_img
  assign ram_rdata = (ram_addr < AW'(NCMD)) ? cmd_img[ram_addr[3:0]] : mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_we)    we_tot   <= we_tot + 1;
    if (line_done) done_tot <= done_tot + 1;
  end

  always @(posedge sensor_sclk or negedge rst_n) begin
    if (!rst_n) rise_n = 0;
    else begin
      rise_n = rise_n + 1;
      if (rise_n < 64) rec[rise_n] = sensor_sdin;
    end
  end

  always @(negedge sensor_sclk or negedge rst_n) begin
    if (!rst_n) fall_n = 0;
    else begin
      fall_n = fall_n + 1;
      if (fall_n == NCMD + 1) e_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] v, input int gap);
    @(negedge sensor_sclk) sensor_sdout = 1'b0;
    for (int b = 0; b < 8; b++) @(negedge sensor_sclk) sensor_sdout = v[b];
    @(negedge sensor_sclk) sensor_sdout = 1'b1;
    repeat (gap) @(negedge sensor_sclk);
  endtask

  task automatic check_reset_state();
    chk(ram_addr == '0,   "R1 addr",  int'(ram_addr), 0);
    chk(sensor_sdin == 0, "R1 sdin",  int'(sensor_sdin), 0);
    chk(ram_we == 0,      "R1 we",    int'(ram_we), 0);
    chk(line_done == 0,   "R1 done",  int'(line_done), 0);
    chk(sensor_sclk == 0, "R1 sclk",  int'(sensor_sclk), 0);
  endtask

  task automatic check_cmd(input logic [15:0] pat);
    int n = 0;
    while (rise_n < 21 && n < 500) begin @(negedge clk); n++; end
    chk(rec[1] == 1'b0, "R3 first rise idle", int'(rec[1]), 0);
    for (int k = 1; k <= NCMD; k++)
      chk(rec[k+1] == pat[k-1], "R3 command bit", int'(rec[k+1]), int'(pat[k-1]));
    chk(rec[NCMD+2] == 1'b0 && rec[NCMD+3] == 1'b0 && rec[NCMD+4] == 1'b0,
        "R4 sdin low after commands", int'(rec[NCMD+2]), 0);
  endtask

  task automatic run_line(input int tick_c, input logic [31:0] bytes, input int gap, input bit decoy);
    int w0, d0, n;
    logic [7:0] got;
    wait_until(tick_c + 8);
    w0 = we_tot; d0 = done_tot;
    for (int j = 0; j < NBYTES; j++) send_frame(bytes[8*j +: 8], gap);
    n = 0;
    while (done_tot == d0 && n < 200) begin @(negedge clk); n++; end
    chk(done_tot == d0 + 1, "R7 one done per line", done_tot - d0, 1);
    chk(ram_addr == AW'(BASE), "R7 address back at base", int'(ram_addr), BASE);
    chk(we_tot - w0 == 8 * NBYTES, "R5 data bits only written", we_tot - w0, 8 * NBYTES);
    chk(sensor_sdin == 1'b0, "R4 sdin low in capture", int'(sensor_sdin), 0);
    for (int j = 0; j < NBYTES; j++) begin
      for (int b = 0; b < 8; b++) got[b] = mem[BASE + 8*j + b];
      chk(got == bytes[8*j +: 8], "R6 pixel byte placement", int'(got), int'(bytes[8*j +: 8]));
    end
    if (decoy) begin
      w0 = we_tot; d0 = done_tot;
      send_frame(8'hFF, 0);
      repeat (2) @(negedge clk);
      chk(we_tot == w0, "R8 start before expiry ignored", we_tot - w0, 0);
      chk(done_tot == d0, "R8 no done from decoy", done_tot - d0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tick0, t64, n;
    time t0, t1, t2;
    logic [31:0] bytes;
    checks = 0; failures = 0; we_tot = 0; done_tot = 0; e_cyc = 0;
    rst_n = 1'b0; sensor_sdout = 1'b1; line_period = LW'(300);
    cmd_img = 16'hA5C3;
    for (int a = 0; a < (1 << AW); a++) mem[a] = 1'b0;
    #12;
    check_reset_state();
    @(negedge clk) rst_n = 1'b1;

    check_cmd(16'hA5C3);

    @(posedge sensor_sclk) t0 = $time;
    @(negedge sensor_sclk) t1 = $time;
    @(posedge sensor_sclk) t2 = $time;
    chk(t1 - t0 == 10, "R2 sclk high time", int'(t1 - t0), 10);
    chk(t2 - t0 == 20, "R2 sclk period", int'(t2 - t0), 20);

    n = 0;
    while (e_cyc == 0 && n < 500) begin @(negedge clk); n++; end
    tick0 = e_cyc + 1;

    // sweep every byte value over 64 lines at period 300
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < NBYTES; j++) bytes[8*j +: 8] = 8'(4*k + j);
      run_line(tick0 + 300*k, bytes, (k % 2) * 2, (k % 4) == 3);
    end

    // new period takes effect at the expiry after the change
    line_period = LW'(250);
    t64 = tick0 + 300*64;
    run_line(t64,       32'h3C5A_A5C3, 0, 1'b0);
    run_line(t64 + 250, 32'hF00F_817E, 0, 1'b0);
    run_line(t64 + 500, 32'h7856_3412, 1, 1'b0);

    // second reset with another command image
    @(negedge clk) rst_n = 1'b0;
    #1;
    check_reset_state();
    cmd_img = 16'h3C69;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_cmd(16'h3C69);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule